// File: doc/BRIEF.md
# Same-Address Collision Busy Arbiter

This block sits beside a two-port memory array and watches both ports every clock. When both ports are enabled and present the same address, it grants the location to one port and raises busy toward the other. Any write from the port that sees busy is blocked before it reaches the array. The decision uses only the enables and the addresses. Whether either access is a read or a write does not matter.

A mode input selects the role. As master, the block makes the decision and drives registered busy flags toward both ports. As slave, it makes no decision and keeps its busy outputs low. In that role two active-low inhibit inputs, normally fed from a master's busy flags, gate the writes of each port. The gated write enables are the only path from a port's write strobe to the array. A collision-event output, the OR of the two busy flags, can serve as an error interrupt.

Busy is registered. The write strobe in a cycle is therefore qualified by the busy flag computed from the enables and addresses of the previous cycle. Address and enable must settle one cycle before the strobe. All pins are plain control and status: there is no streaming data path and no valid/ready handshake.

Top module: `dpram_busy_arbiter`

## Requirements
- R1: In master mode, with both enables high and equal addresses at a rising edge, exactly one busy output is high after that edge. The write inputs have no effect on this.
- R2: If neither port was enabled on that address in the previous cycle, both ports arrive together and the left port wins: r_busy goes high and l_busy stays low.
- R3: A port that was enabled on the same address in the previous cycle keeps ownership against a newcomer. During a continuing collision the owner does not change.
- R4: l_busy and r_busy are never high together.
- R5: Busy clears at the first rising edge at which the collision no longer holds, for example because the owner's enable fell or its address changed.
- R6: In master mode a port's write is suppressed (wr_gated low) whenever its busy output is high. On the first cycle of a collision the registered busy is still low, so a write from that port is not yet blocked.
- R7: A port's gated write equals en AND wr AND NOT inhibit. Inhibit is the port's own busy output in master mode, or its inhibit input being low in slave mode.
- R8: In slave mode (master_mode = 0) no decision is made: both busy outputs are low from the first edge in slave mode onward. A low on a port's busy_n input blocks that port's writes, and a high leaves them unblocked.
- R9: collision_evt is high exactly when either busy output is high.
- R10: While reset is held, and right after it, both busy outputs and collision_evt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master (decide and drive busy), 0 = slave (inhibit inputs only) |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| l_busy_n_in | input | 1 | Left write inhibit, active low, used in slave mode |
| r_busy_n_in | input | 1 | Right write inhibit, active low, used in slave mode |
| l_busy | output | 1 | Busy toward the left port (master mode) |
| r_busy | output | 1 | Busy toward the right port (master mode) |
| l_wr_gated | output | 1 | Left write enable passed to the array |
| r_wr_gated | output | 1 | Right write enable passed to the array |
| collision_evt | output | 1 | OR of the two busy flags |

## Verification
On every cycle the assertions check the following:
- The two busy flags are never high together.
- Busy only follows a collision seen at the previous edge.
- A gated write never appears without its raw enable and strobe.
- In master mode a busy-flagged port never writes.
- In slave mode a low inhibit input always blocks the write.

Only the bench's scenarios can show which port should win: left on a tie, the earlier holder otherwise. They also show when busy releases, that the write level has no effect on the decision, and that a write on the first collision cycle still passes. The bench checks these against its own cycle model under random and directed traffic.

// File: rtl/dpram_busy_pkg.sv
package dpram_busy_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/busy_owner_track.sv
module busy_owner_track
  import dpram_busy_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              busy_l,
  output logic              busy_r
);
  logic              collide;
  logic              l_held, r_held;
  logic              prev_l_en, prev_r_en;
  logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
  owner_e            owner_q, owner_d;

  assign collide = l_en && r_en && (l_addr == r_addr);
  assign l_held  = prev_l_en && (prev_l_addr == l_addr);
  assign r_held  = prev_r_en && (prev_r_addr == r_addr);

  always_comb begin
    owner_d = OWN_NONE;
    if (master_mode && collide) begin
      if (owner_q == OWN_RIGHT && r_held)      owner_d = OWN_RIGHT;
      else if (owner_q == OWN_LEFT && l_held)  owner_d = OWN_LEFT;
      else if (r_held && !l_held)              owner_d = OWN_RIGHT;
      else                                     owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q     <= OWN_NONE;
      prev_l_en   <= 1'b0;
      prev_r_en   <= 1'b0;
      prev_l_addr <= '0;
      prev_r_addr <= '0;
    end else begin
      owner_q     <= owner_d;
      prev_l_en   <= l_en;
      prev_r_en   <= r_en;
      prev_l_addr <= l_addr;
      prev_r_addr <= r_addr;
    end
  end

  assign busy_l = (owner_q == OWN_RIGHT);
  assign busy_r = (owner_q == OWN_LEFT);

  assert_busy_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l && busy_r));

  assert_busy_needs_collision_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l || busy_r) |-> $past(collide && master_mode));
endmodule

// File: rtl/port_write_gate.sv
module port_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic en,
  input  logic wr,
  input  logic busy_q,
  input  logic busy_n_in,
  output logic wr_gated
);
  logic inhibit;

  assign inhibit  = master_mode ? busy_q : !busy_n_in;
  assign wr_gated = en && wr && !inhibit;

  assert_gate_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gated |-> (en && wr));

  assert_busy_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && busy_q) |-> !wr_gated);

  assert_slave_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !busy_n_in) |-> !wr_gated);
endmodule

// File: rtl/dpram_busy_arbiter.sv
module dpram_busy_arbiter #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_n_in,
  input  logic              r_busy_n_in,
  output logic              l_busy,
  output logic              r_busy,
  output logic              l_wr_gated,
  output logic              r_wr_gated,
  output logic              collision_evt
);
  busy_owner_track #(.ADDR_W(ADDR_W)) owner_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .busy_l(l_busy), .busy_r(r_busy)
  );

  port_write_gate left_gate_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .en(l_en), .wr(l_wr), .busy_q(l_busy), .busy_n_in(l_busy_n_in),
    .wr_gated(l_wr_gated)
  );

  port_write_gate right_gate_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .en(r_en), .wr(r_wr), .busy_q(r_busy), .busy_n_in(r_busy_n_in),
    .wr_gated(r_wr_gated)
  );

  assign collision_evt = l_busy || r_busy;

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!master_mode) |-> (!l_busy && !r_busy));
endmodule

// File: tb/dpram_busy_arbiter_tb_top.sv
module dpram_busy_arbiter_tb_top;
  localparam int AW = 13;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n_in = 1, r_busy_n_in = 1;
  logic l_busy, r_busy, l_wr_gated, r_wr_gated, collision_evt;
  int checks = 0, errors = 0;
  bit done = 0;

  // model state: 0 none, 1 left owns, 2 right owns
  int m_owner = 0;
  logic m_pl_en = 0, m_pr_en = 0;
  logic [AW-1:0] m_pl_addr = '0, m_pr_addr = '0;

  always #4 clk = ~clk;

  dpram_busy_arbiter #(.ADDR_W(AW)) dut_i (.*);

  function automatic int next_owner();
    bit coll, lh, rh;
    coll = l_en && r_en && (l_addr == r_addr);
    lh = m_pl_en && (m_pl_addr == l_addr);
    rh = m_pr_en && (m_pr_addr == r_addr);
    if (!master_mode || !coll) return 0;
    if (m_owner == 2 && rh) return 2;
    if (m_owner == 1 && lh) return 1;
    if (rh && !lh) return 2;
    return 1;
  endfunction

  function automatic bit exp_gate(bit en, bit wr, bit busy, bit bn);
    return en && wr && !(master_mode ? busy : !bn);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit ms, bit le, bit lw, logic [AW-1:0] la,
                      bit re, bit rw, logic [AW-1:0] ra, bit lbn, bit rbn);
    bit eb_l, eb_r;
    @(negedge clk);
    master_mode = ms; l_en = le; l_wr = lw; l_addr = la;
    r_en = re; r_wr = rw; r_addr = ra; l_busy_n_in = lbn; r_busy_n_in = rbn;
    #1;
    eb_l = (m_owner == 2); eb_r = (m_owner == 1);
    chk({tag, " l_wr_gated R6/R7/R8"}, l_wr_gated, exp_gate(le, lw, eb_l, lbn));
    chk({tag, " r_wr_gated R6/R7/R8"}, r_wr_gated, exp_gate(re, rw, eb_r, rbn));
    @(posedge clk);
    m_owner = next_owner();
    m_pl_en = le; m_pr_en = re; m_pl_addr = la; m_pr_addr = ra;
    #1;
    chk({tag, " l_busy"}, l_busy, m_owner == 2);
    chk({tag, " r_busy"}, r_busy, m_owner == 1);
    chk({tag, " collision_evt R9"}, collision_evt, m_owner != 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    chk("reset l_busy R10", l_busy, 0);
    chk("reset r_busy R10", r_busy, 0);
    chk("reset evt R10", collision_evt, 0);
    @(negedge clk); rst_n = 1;

    // R2: tie, left wins; write from right on first cycle still passes (R6)
    step("R2 tie", 1, 1, 0, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1);
    chk("R2 right busy", r_busy, 1);
    // R6: right write now blocked, left write passes (R7)
    step("R6 blocked", 1, 1, 1, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1);
    // R5: owner leaves, busy clears
    step("R5 release", 1, 0, 0, 13'h1FFF, 1, 1, 13'h1FFF, 1, 1);
    chk("R5 r_busy cleared", r_busy, 0);
    // R3: right holds address 5, left joins later
    step("R3 hold", 1, 1, 0, 13'h0004, 1, 0, 13'h0005, 1, 1);
    step("R3 join", 1, 1, 1, 13'h0005, 1, 0, 13'h0005, 1, 1);
    chk("R3 left busy", l_busy, 1);
    step("R3 keep", 1, 1, 1, 13'h0005, 1, 1, 13'h0005, 1, 1);
    chk("R3 left still busy", l_busy, 1);
    chk("R3 left write blocked", l_wr_gated, 0);
    // R5: owner changes address
    step("R5 move", 1, 1, 0, 13'h0005, 1, 0, 13'h0006, 1, 1);
    chk("R5 l_busy cleared", l_busy, 0);
    // R1: write level has no effect on decision
    step("R1 rw", 1, 1, 1, 13'h0010, 1, 1, 13'h0010, 1, 1);
    chk("R1 busy with writes", r_busy, 1);
    // R8: slave mode
    step("R8 slave", 0, 1, 1, 13'h0010, 1, 1, 13'h0010, 0, 1);
    chk("R8 no busy in slave", r_busy | l_busy, 0);
    step("R8 inhibit", 0, 1, 1, 13'h0010, 1, 1, 13'h0010, 0, 1);
    chk("R8 left inhibited", l_wr_gated, 0);
    chk("R8 right allowed", r_wr_gated, 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pick[5] = '{13'h0, 13'h1, 13'h2, 13'h3, 13'h1FFF};
      step("rand R1/R2/R3/R4/R5", ($urandom % 10) != 0,
           $urandom % 4 != 0, $urandom % 2, pick[$urandom % 5],
           $urandom % 4 != 0, $urandom % 2, pick[$urandom % 5],
           $urandom % 5 != 0, $urandom % 5 != 0);
      chk("rand R4 exclusive", l_busy & r_busy, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule